// File: doc/BRIEF.md
# Configuration Security Lock Controller

This block guards the configuration storage of a small programmable logic device. A host issues one-bit commands over a valid/ready channel. Each command names an operation, a 13-bit address and a data bit. The storage has three regions: a main fuse array of `ARRAY_BITS` bits, a 64-bit user signature for free-form user data, and a single security bit. A separate bank of `NREG` device registers can be forced to known values through the preload command. Test sequences use this to start from a chosen state.

Once the security bit is set, the array can no longer be read back and the registers can no longer be preloaded. The signature stays readable and writable. The security bit acts from the very next accepted command and needs no reset. Only an erase clears it. The erase sweeps the array one word per cycle, and it also clears the signature and, last of all, the security bit.

Top module: `cfg_guard`

## Requirements
- R1: After reset, `cmd_ready` is 1, `rsp_valid` is 0, `preload_q` is all zeros, and every array and signature bit reads 0 with no error.
- R2: Opcode encoding is 0 = write, 1 = verify, 2 = preload, 3 = erase. For every command except erase, a response is given as a one-cycle `rsp_valid` pulse in the cycle after acceptance. A verify of an array address (0 to `ARRAY_BITS`-1) returns the bit last written there, with `rsp_err` 0.
- R3: The signature occupies addresses 0x1800 to 0x183F, with bit i at 0x1800+i. It can be written and verified with `rsp_err` 0 whether or not the security bit is set.
- R4: While the security bit is set, a verify of an array address returns `rsp_err` 1 and `rsp_data` 0.
- R5: While the security bit is set, a preload returns `rsp_err` 1 and leaves `preload_q` unchanged.
- R6: Writing 1 to address 0x1FFF sets the security bit, and the command accepted in the very next cycle already sees it. Writing 0 there has no effect. A verify of 0x1FFF returns the security bit with no error.
- R7: An erase drops `cmd_ready` for the length of the sweep. When the sweep ends it returns one response with `rsp_err` 0. After it, the array, the signature and the security bit all read 0.
- R8: An unlocked preload with an address below `NREG` sets `preload_q[address]` to the data bit, with `rsp_err` 0. A preload with an address of `NREG` or above returns `rsp_err` 1 and changes nothing.
- R9: A write or verify to an address outside the array, the signature and 0x1FFF returns `rsp_err` 1 and `rsp_data` 0, and changes no stored bit.
- R10: While the security bit is set, writes to the array are still accepted, with `rsp_err` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (low during an erase sweep) |
| cmd_op | input | 2 | Operation: 0 write, 1 verify, 2 preload, 3 erase |
| cmd_addr | input | ADDR_W (13) | Bit address, or register index for preload |
| cmd_data | input | 1 | Bit to write or preload |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Command refused |
| rsp_data | output | 1 | Bit read by verify (0 when refused) |
| preload_q | output | NREG (10) | Device register bank |

## Verification
The assertions rely on three things about the inputs. First, `cmd_op` and `cmd_addr` are stable while `cmd_valid` is high. Second, the host treats `rsp_valid` as a pulse that needs no acknowledge. Third, no command is expected to be taken while `cmd_ready` is low. The stimulus keeps to this by driving each command away from the clock edge and holding it until the edge where `cmd_ready` was seen high. Random traffic draws its addresses from the array, the signature, the register indices and the unmapped gap. It never writes the security address, so the point where the lock is set is fixed by directed steps.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

  typedef enum logic [1:0] {
    OP_WRITE   = 2'd0,
    OP_VERIFY  = 2'd1,
    OP_PRELOAD = 2'd2,
    OP_ERASE   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RGN_ARRAY = 2'd0,
    RGN_SIG   = 2'd1,
    RGN_LOCK  = 2'd2,
    RGN_NONE  = 2'd3
  } rgn_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } state_e;

endpackage

// File: rtl/cfg_guard_decode.sv
module cfg_guard_decode
  import cfg_guard_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned ARRAY_BITS = 1024,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned SIG_BITS   = 64,
  parameter int unsigned SIG_BASE   = 6144,
  parameter int unsigned LOCK_ADDR  = 8191
) (
  input  logic [ADDR_W-1:0]                         addr,
  output rgn_e                                      rgn,
  output logic [$clog2(ARRAY_BITS/WORD_W)-1:0]      word_idx,
  output logic [$clog2(WORD_W)-1:0]                 bit_idx,
  output logic [$clog2(SIG_BITS)-1:0]               sig_idx
);

  localparam int unsigned NWORDS = ARRAY_BITS / WORD_W;
  localparam int unsigned WIDX_W = $clog2(NWORDS);
  localparam int unsigned BIDX_W = $clog2(WORD_W);
  localparam int unsigned SIDX_W = $clog2(SIG_BITS);

  logic [31:0] a32;

  always_comb begin
    a32      = 32'(addr);
    word_idx = WIDX_W'(a32 >> BIDX_W);
    bit_idx  = BIDX_W'(a32);
    sig_idx  = SIDX_W'(a32 - SIG_BASE);
    if (a32 == LOCK_ADDR) begin
      rgn = RGN_LOCK;
    end else if (a32 < ARRAY_BITS) begin
      rgn = RGN_ARRAY;
    end else if ((a32 >= SIG_BASE) && (a32 < SIG_BASE + SIG_BITS)) begin
      rgn = RGN_SIG;
    end else begin
      rgn = RGN_NONE;
    end
  end

endmodule

// File: rtl/cfg_guard_store.sv
module cfg_guard_store #(
  parameter int unsigned ARRAY_BITS = 1024,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned SIG_BITS   = 64
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     arr_we,
  input  logic [$clog2(ARRAY_BITS/WORD_W)-1:0]     arr_widx,
  input  logic [$clog2(WORD_W)-1:0]                arr_bidx,
  input  logic                                     wr_bit,
  input  logic                                     sig_we,
  input  logic [$clog2(SIG_BITS)-1:0]              sig_idx,
  input  logic                                     lock_set,
  input  logic                                     ers_word_en,
  input  logic [$clog2(ARRAY_BITS/WORD_W)-1:0]     ers_widx,
  input  logic                                     ers_sig,
  input  logic                                     ers_lock,
  output logic                                     arr_rd,
  output logic                                     sig_rd,
  output logic                                     lock_q
);

  localparam int unsigned NWORDS = ARRAY_BITS / WORD_W;
  localparam int unsigned WIDX_W = $clog2(NWORDS);

  logic [NWORDS-1:0][WORD_W-1:0] mem_q;

  // One register word per array row, each with its own enable
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic              word_en;
    logic [WORD_W-1:0] word_d;
    logic [WORD_W-1:0] word_q;

    always_comb begin
      word_en = 1'b0;
      word_d  = word_q;
      if (ers_word_en && (ers_widx == WIDX_W'(w))) begin
        word_en = 1'b1;
        word_d  = '0;
      end else if (arr_we && (arr_widx == WIDX_W'(w))) begin
        word_en         = 1'b1;
        word_d[arr_bidx] = wr_bit;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_en) begin
        word_q <= word_d;
      end
    end

    assign mem_q[w] = word_q;
  end

  // User signature
  logic                sig_en;
  logic [SIG_BITS-1:0] sig_d;
  logic [SIG_BITS-1:0] sig_q;

  always_comb begin
    sig_en = sig_we | ers_sig;
    sig_d  = sig_q;
    if (ers_sig) begin
      sig_d = '0;
    end else if (sig_we) begin
      sig_d[sig_idx] = wr_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= '0;
    end else if (sig_en) begin
      sig_q <= sig_d;
    end
  end

  // Sticky security bit: set by a write, cleared only by the erase sweep
  logic lock_en;
  logic lock_d;

  always_comb begin
    lock_en = ers_lock | lock_set;
    lock_d  = ers_lock ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  assign arr_rd = mem_q[arr_widx][arr_bidx];
  assign sig_rd = sig_q[sig_idx];

  // R6: the security bit never drops without the erase sweep
  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && !ers_lock |=> lock_q);

  // R7: the end of the sweep leaves the security bit clear
  assert_erase_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ers_lock |=> !lock_q);

  // R7: a signature clear leaves no bit set
  assert_sig_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ers_sig |=> (sig_q == '0));

endmodule

// File: rtl/cfg_guard_preload.sv
module cfg_guard_preload #(
  parameter int unsigned NREG = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pl_we,
  input  logic [$clog2(NREG)-1:0]  pl_idx,
  input  logic                     pl_bit,
  output logic [NREG-1:0]          regs_q
);

  localparam int unsigned PIDX_W = $clog2(NREG);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic reg_en;

    always_comb begin
      reg_en = pl_we && (pl_idx == PIDX_W'(r));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[r] <= 1'b0;
      end else if (reg_en) begin
        regs_q[r] <= pl_bit;
      end
    end
  end

  // R8: one preload touches at most one register
  assert_single_preload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(regs_q ^ $past(regs_q)) <= 1);

  // R5: with no preload strobe the bank holds
  assert_bank_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pl_we |=> $stable(regs_q));

endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
  import cfg_guard_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned ARRAY_BITS = 1024,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned SIG_BITS   = 64,
  parameter int unsigned SIG_BASE   = 6144,
  parameter int unsigned LOCK_ADDR  = 8191,
  parameter int unsigned NREG       = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_data,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic              rsp_data,
  output logic [NREG-1:0]   preload_q
);

  localparam int unsigned NWORDS = ARRAY_BITS / WORD_W;
  localparam int unsigned WIDX_W = $clog2(NWORDS);
  localparam int unsigned BIDX_W = $clog2(WORD_W);
  localparam int unsigned SIDX_W = $clog2(SIG_BITS);
  localparam int unsigned PIDX_W = $clog2(NREG);

  rgn_e              rgn;
  logic [WIDX_W-1:0] word_idx;
  logic [BIDX_W-1:0] bit_idx;
  logic [SIDX_W-1:0] sig_idx;

  cfg_guard_decode #(
    .ADDR_W     (ADDR_W),
    .ARRAY_BITS (ARRAY_BITS),
    .WORD_W     (WORD_W),
    .SIG_BITS   (SIG_BITS),
    .SIG_BASE   (SIG_BASE),
    .LOCK_ADDR  (LOCK_ADDR)
  ) u_decode (
    .addr     (cmd_addr),
    .rgn      (rgn),
    .word_idx (word_idx),
    .bit_idx  (bit_idx),
    .sig_idx  (sig_idx)
  );

  state_e            state_q, state_d;
  logic [WIDX_W-1:0] sweep_q, sweep_d;
  logic              sweep_en;
  logic              rsp_valid_d, rsp_err_d, rsp_data_d;
  logic              rsp_valid_q, rsp_err_q, rsp_data_q;

  logic              accept;
  op_e               op;
  logic              arr_we, sig_we, lock_set;
  logic              ers_word_en, ers_sig, ers_lock;
  logic              arr_rd, sig_rd, lock_q;
  logic              pl_we, pl_in_range;
  logic [PIDX_W-1:0] pl_idx;

  cfg_guard_store #(
    .ARRAY_BITS (ARRAY_BITS),
    .WORD_W     (WORD_W),
    .SIG_BITS   (SIG_BITS)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .arr_we      (arr_we),
    .arr_widx    (word_idx),
    .arr_bidx    (bit_idx),
    .wr_bit      (cmd_data),
    .sig_we      (sig_we),
    .sig_idx     (sig_idx),
    .lock_set    (lock_set),
    .ers_word_en (ers_word_en),
    .ers_widx    (sweep_q),
    .ers_sig     (ers_sig),
    .ers_lock    (ers_lock),
    .arr_rd      (arr_rd),
    .sig_rd      (sig_rd),
    .lock_q      (lock_q)
  );

  cfg_guard_preload #(
    .NREG (NREG)
  ) u_preload (
    .clk    (clk),
    .rst_n  (rst_n),
    .pl_we  (pl_we),
    .pl_idx (pl_idx),
    .pl_bit (cmd_data),
    .regs_q (preload_q)
  );

  // Next-state and command decode
  always_comb begin
    cmd_ready   = (state_q == ST_IDLE);
    accept      = cmd_valid && cmd_ready;
    op          = op_e'(cmd_op);
    pl_in_range = (32'(cmd_addr) < NREG);
    pl_idx      = PIDX_W'(cmd_addr);

    state_d     = state_q;
    sweep_d     = sweep_q;
    sweep_en    = 1'b0;
    rsp_valid_d = 1'b0;
    rsp_err_d   = 1'b0;
    rsp_data_d  = 1'b0;
    arr_we      = 1'b0;
    sig_we      = 1'b0;
    lock_set    = 1'b0;
    pl_we       = 1'b0;
    ers_word_en = 1'b0;
    ers_sig     = 1'b0;
    ers_lock    = 1'b0;

    if (state_q == ST_SWEEP) begin
      ers_word_en = 1'b1;
      if (sweep_q == WIDX_W'(NWORDS - 1)) begin
        ers_lock    = 1'b1;
        state_d     = ST_IDLE;
        rsp_valid_d = 1'b1;
      end else begin
        sweep_en = 1'b1;
        sweep_d  = sweep_q + 1'b1;
      end
    end else if (accept) begin
      rsp_valid_d = 1'b1;
      unique case (op)
        OP_WRITE: begin
          unique case (rgn)
            RGN_ARRAY: arr_we    = 1'b1;
            RGN_SIG:   sig_we    = 1'b1;
            RGN_LOCK:  lock_set  = cmd_data;
            default:   rsp_err_d = 1'b1;
          endcase
        end
        OP_VERIFY: begin
          unique case (rgn)
            RGN_ARRAY: begin
              if (lock_q) rsp_err_d  = 1'b1;
              else        rsp_data_d = arr_rd;
            end
            RGN_SIG:   rsp_data_d = sig_rd;
            RGN_LOCK:  rsp_data_d = lock_q;
            default:   rsp_err_d  = 1'b1;
          endcase
        end
        OP_PRELOAD: begin
          if (lock_q || !pl_in_range) rsp_err_d = 1'b1;
          else                        pl_we     = 1'b1;
        end
        OP_ERASE: begin
          rsp_valid_d = 1'b0;
          ers_sig     = 1'b1;
          state_d     = ST_SWEEP;
          sweep_en    = 1'b1;
          sweep_d     = '0;
        end
        default: rsp_err_d = 1'b1;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      sweep_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
      rsp_data_q  <= rsp_data_d;
      if (sweep_en) begin
        sweep_q <= sweep_d;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_data  = rsp_data_q;

  // R4: array read-back is refused while secured
  assert_verify_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op == OP_VERIFY) && (rgn == RGN_ARRAY) && lock_q
    |=> rsp_valid && rsp_err && !rsp_data);

  // R5: preload is refused and the bank is untouched while secured
  assert_preload_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op == OP_PRELOAD) && lock_q
    |=> rsp_valid && rsp_err && $stable(preload_q));

  // R3: signature read-back is never refused
  assert_sig_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op == OP_VERIFY) && (rgn == RGN_SIG) |=> rsp_valid && !rsp_err);

  // R7: the cycle after an erase is taken, no command is taken and no response given
  assert_erase_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op == OP_ERASE) |=> !cmd_ready && !rsp_valid);

  // R6: a lock write shows up on the very next cycle
  assert_lock_immediate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op == OP_WRITE) && (rgn == RGN_LOCK) && cmd_data |=> lock_q);

endmodule

// File: tb/test_cfg_guard.sv
module test_cfg_guard;

  localparam int ARRAY_BITS = 1024;
  localparam int SIG_BASE   = 6144;
  localparam int SIG_BITS   = 64;
  localparam int LOCK_ADDR  = 8191;
  localparam int NREG       = 10;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [1:0]  cmd_op;
  logic [12:0] cmd_addr;
  logic        cmd_data;
  logic        rsp_valid;
  logic        rsp_err;
  logic        rsp_data;
  logic [NREG-1:0] preload_q;

  cfg_guard i_cfg_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_data  (rsp_data),
    .preload_q (preload_q)
  );

  initial clk = 1'b0;
  always #4ns clk = ~clk;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  bit            exp_arr [ARRAY_BITS];
  bit            exp_sig [SIG_BITS];
  bit            exp_lock;
  bit [NREG-1:0] exp_pl;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference model of the requirements; updates state and gives the expected response
  function automatic void predict(input int op, input int addr, input bit d,
                                  output bit e_err, output bit e_dat);
    e_err = 1'b0;
    e_dat = 1'b0;
    case (op)
      0: begin
        if (addr == LOCK_ADDR) begin
          if (d) exp_lock = 1'b1;
        end else if (addr < ARRAY_BITS) exp_arr[addr] = d;
        else if (addr >= SIG_BASE && addr < SIG_BASE + SIG_BITS) exp_sig[addr - SIG_BASE] = d;
        else e_err = 1'b1;
      end
      1: begin
        if (addr == LOCK_ADDR) e_dat = exp_lock;
        else if (addr < ARRAY_BITS) begin
          if (exp_lock) e_err = 1'b1;
          else          e_dat = exp_arr[addr];
        end else if (addr >= SIG_BASE && addr < SIG_BASE + SIG_BITS) e_dat = exp_sig[addr - SIG_BASE];
        else e_err = 1'b1;
      end
      2: begin
        if (exp_lock || addr >= NREG) e_err = 1'b1;
        else exp_pl[addr] = d;
      end
      default: begin
        foreach (exp_arr[i]) exp_arr[i] = 1'b0;
        foreach (exp_sig[i]) exp_sig[i] = 1'b0;
        exp_lock = 1'b0;
      end
    endcase
  endfunction

  task automatic do_cmd(input int op, input int addr, input bit d, input string req);
    bit e_err, e_dat;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 2'(op);
    cmd_addr  = 13'(addr);
    cmd_data  = d;
    while (!cmd_ready) @(negedge clk);
    predict(op, addr, d, e_err, e_dat);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op == 3) begin
      int waited = 0;
      chk({req, " busy"}, 32'(cmd_ready), 32'd0);
      while (!rsp_valid && waited < 500) begin
        @(negedge clk);
        waited++;
      end
      chk({req, " done"}, 32'(rsp_valid), 32'd1);
      chk({req, " err"}, 32'(rsp_err), 32'd0);
    end else begin
      chk({req, " valid"}, 32'(rsp_valid), 32'd1);
      chk({req, " err"}, 32'(rsp_err), 32'(e_err));
      chk({req, " data"}, 32'(rsp_data), 32'(e_dat));
      if (op == 2) chk({req, " bank"}, 32'(preload_q), 32'(exp_pl));
    end
  endtask

  function automatic int pick_addr(input int cls);
    case (cls)
      0: return int'($urandom % ARRAY_BITS);
      1: return SIG_BASE + int'($urandom % SIG_BITS);
      2: return ARRAY_BITS + int'($urandom % (SIG_BASE - ARRAY_BITS));
      default: return int'($urandom % 16);
    endcase
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    bit e1, d1, e2, d2;
    int unsigned seed_v;
    seed_v    = $urandom(32'd4242);
    cmd_valid = 1'b0;
    cmd_op    = 2'd0;
    cmd_addr  = '0;
    cmd_data  = 1'b0;
    exp_lock  = 1'b0;
    exp_pl    = '0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 ready", 32'(cmd_ready), 32'd1);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 bank", 32'(preload_q), 32'd0);
    do_cmd(1, 17, 1'b0, "R1 array zero");
    do_cmd(1, SIG_BASE + 5, 1'b0, "R1 sig zero");

    // R2: array write and read-back at the edges
    do_cmd(0, 0, 1'b1, "R2 write low");
    do_cmd(0, ARRAY_BITS - 1, 1'b1, "R2 write high");
    do_cmd(1, 0, 1'b0, "R2 verify low");
    do_cmd(1, ARRAY_BITS - 1, 1'b0, "R2 verify high");

    // R3: signature edges
    do_cmd(0, SIG_BASE, 1'b1, "R3 write first");
    do_cmd(0, SIG_BASE + SIG_BITS - 1, 1'b1, "R3 write last");
    do_cmd(1, SIG_BASE + SIG_BITS - 1, 1'b0, "R3 verify last");

    // R9: unmapped space
    do_cmd(0, ARRAY_BITS, 1'b1, "R9 write gap");
    do_cmd(1, ARRAY_BITS, 1'b0, "R9 verify gap");
    do_cmd(1, SIG_BASE + SIG_BITS, 1'b0, "R9 verify past sig");

    // R8: preload range
    do_cmd(2, NREG - 1, 1'b1, "R8 preload top");
    do_cmd(2, NREG, 1'b1, "R8 preload out of range");

    // Random unlocked traffic (R2 R3 R8 R9)
    for (int i = 0; i < 300; i++) begin
      int op  = int'($urandom % 3);
      int cls = (op == 2) ? 3 : int'($urandom % 3);
      do_cmd(op, pick_addr(cls), 1'($urandom), "R2 random unlocked");
    end

    // R6: writing 0 to the lock address changes nothing
    do_cmd(0, LOCK_ADDR, 1'b0, "R6 write zero");
    do_cmd(1, LOCK_ADDR, 1'b0, "R6 still open");

    // R6: lock write followed back-to-back by an array verify
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = 13'(LOCK_ADDR); cmd_data = 1'b1;
    predict(0, LOCK_ADDR, 1'b1, e1, d1);
    @(posedge clk);
    @(negedge clk);
    cmd_op = 2'd1; cmd_addr = 13'd0; cmd_data = 1'b0;
    predict(1, 0, 1'b0, e2, d2);
    chk("R6 lock write rsp", 32'({rsp_valid, rsp_err}), 32'({1'b1, e1}));
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R6 immediate refusal", 32'({rsp_valid, rsp_err, rsp_data}), 32'({1'b1, e2, d2}));
    do_cmd(1, LOCK_ADDR, 1'b0, "R6 lock reads one");

    // Random locked traffic (R3 R4 R5 R10)
    for (int i = 0; i < 200; i++) begin
      int op  = int'($urandom % 3);
      int cls = (op == 2) ? 3 : int'($urandom % 2);
      string tag = (op == 2) ? "R5 locked preload" :
                   (cls == 1) ? "R3 locked sig" :
                   (op == 1) ? "R4 locked verify" : "R10 locked write";
      do_cmd(op, pick_addr(cls), 1'($urandom), tag);
    end
    do_cmd(0, LOCK_ADDR, 1'b0, "R6 no clear by write");
    do_cmd(1, LOCK_ADDR, 1'b0, "R6 lock held");

    // R7: erase clears everything and reopens access
    do_cmd(3, 0, 1'b0, "R7 erase");
    do_cmd(1, LOCK_ADDR, 1'b0, "R7 lock cleared");
    do_cmd(1, 0, 1'b0, "R7 array cleared");
    do_cmd(1, ARRAY_BITS - 1, 1'b0, "R7 array top cleared");
    do_cmd(1, SIG_BASE, 1'b0, "R7 sig cleared");
    do_cmd(2, 3, 1'b1, "R8 preload after erase");

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

endmodule